// File: doc/BRIEF.md
# Shared-Timer Input Debounce Unit

This unit filters a bank of synchronized input pins. The pins share a small pool of three period registers. Each pin carries a 2-bit timer code that picks one of those periods, or picks none. When a code of zero is selected, the pin passes straight through. The code is held in two select words. One word holds the high bit of every pin's code, and the other word holds the low bit, each at the pin's own bit position.

A debounced pin changes its filtered output only after its input has disagreed with that output for a whole period of consecutive clock cycles. Software programs the select words and the period words through a plain single-cycle register port. The select words are always writable. Software is expected to convert a wanted time into a cycle count by rounding any fraction of a cycle upwards, so that the count is never shorter than the time asked for.

Top module: `dbn_unit`

## Requirements
- R1: After reset, both select words and all three period words read as zero, so every pin is in bypass and pin_out equals pin_in.
- R2: Register map, by byte address. Address 0x00 holds code bit 1 of every pin and address 0x04 holds code bit 0, both at the pin's bit position. Addresses 0x10, 0x14 and 0x18 hold the periods for codes 1, 2 and 3. A write takes effect on the clock edge where reg_en and reg_we are high. reg_rdata returns the addressed register combinationally. Any other address reads zero, and writes to it change nothing.
- R3: A pin whose code is 0 drives pin_out equal to pin_in in the same cycle.
- R4: A pin with a nonzero code and a period P greater than zero keeps its output for the first P-1 rising edges after its input starts to differ from the output. It takes the new value after the P-th consecutive edge at which the input still differs.
- R5: An input that returns to the current output value before P consecutive differing edges restarts the count from zero.
- R6: A selected period of 0 behaves as bypass, with pin_out equal to pin_in in the same cycle.
- R7: A write that changes a pin's code restarts that pin's count. A write to the period register that the pin currently selects also restarts its count, even when the value written is the same.
- R8: Pins that select the same code share its period. Pins on different codes are filtered independently with their own periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin inputs |
| pin_out | output | 32 | Filtered pin values |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable, qualified by reg_en |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |

## Verification
The assertions check several properties on every cycle. The stability count of each debounced pin always stays below its period, and the count sits at zero while a pin is in bypass. A debounced pin never moves while its input agrees with its output, and a pin with a period of one follows its input after a single edge. The exact edge at which a longer period releases the output can only be shown by the bench's scenarios. The same is true of a bounce restarting the count, of a rewrite of a period or a code restarting it, of several pins sharing one period, and of an unmapped address leaving the registers unchanged.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NUM_TIMERS = 3;
    localparam int CODE_W     = 2;

    localparam logic [ADDR_W-1:0] ADR_CODE_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CODE_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_PER_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_PER_END  = ADR_PER_BASE + ADDR_W'(4 * NUM_TIMERS);

    typedef enum logic [1:0] {
        RK_NONE,
        RK_CODE_HI,
        RK_CODE_LO,
        RK_PERIOD
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [CODE_W-1:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic reg_dec_t reg_decode(input logic [ADDR_W-1:0] addr);
        reg_dec_t d;
        logic [ADDR_W-1:0] rel;
        d.kind = RK_NONE;
        d.idx  = '0;
        rel    = addr - ADR_PER_BASE;
        if (addr == ADR_CODE_HI) begin
            d.kind = RK_CODE_HI;
        end else if (addr == ADR_CODE_LO) begin
            d.kind = RK_CODE_LO;
        end else if (addr >= ADR_PER_BASE && addr < ADR_PER_END && addr[1:0] == 2'b00) begin
            d.kind = RK_PERIOD;
            d.idx  = rel[CODE_W+1:2];
        end
        return d;
    endfunction

endpackage

// File: rtl/dbn_regs.sv
module dbn_regs
    import dbn_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  reg_req_t                             req,
    output logic [DATA_W-1:0]                    rdata,
    output logic [NUM_PINS-1:0]                  code_hi,
    output logic [NUM_PINS-1:0]                  code_lo,
    output logic [NUM_TIMERS-1:0][DATA_W-1:0]    period,
    output logic [NUM_PINS-1:0]                  code_chg,
    output logic [NUM_TIMERS-1:0]                period_wr
);

    reg_dec_t dec;
    logic     wr;

    assign dec = reg_decode(req.addr);
    assign wr  = req.en && req.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_hi <= '0;
            code_lo <= '0;
        end else if (wr && dec.kind == RK_CODE_HI) begin
            code_hi <= req.wdata[NUM_PINS-1:0];
        end else if (wr && dec.kind == RK_CODE_LO) begin
            code_lo <= req.wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        code_chg = '0;
        if (wr && dec.kind == RK_CODE_HI) code_chg = req.wdata[NUM_PINS-1:0] ^ code_hi;
        if (wr && dec.kind == RK_CODE_LO) code_chg = req.wdata[NUM_PINS-1:0] ^ code_lo;
    end

    for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_period
        assign period_wr[k] = wr && dec.kind == RK_PERIOD && dec.idx == CODE_W'(k);
        always_ff @(posedge clk) begin
            if (rst)               period[k] <= '0;
            else if (period_wr[k]) period[k] <= req.wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.kind)
            RK_CODE_HI: rdata[NUM_PINS-1:0] = code_hi;
            RK_CODE_LO: rdata[NUM_PINS-1:0] = code_lo;
            RK_PERIOD: begin
                for (int k = 0; k < NUM_TIMERS; k++)
                    if (dec.idx == CODE_W'(k)) rdata = period[k];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbn_filter.sv
module dbn_filter
    import dbn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              bypass,
    input  logic [DATA_W-1:0] limit,
    input  logic              restart,
    output logic              dout,
    output logic [DATA_W-1:0] cnt
);

    logic filt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (bypass) begin
            filt <= din;
            cnt  <= '0;
        end else if (restart || din == filt) begin
            cnt  <= '0;
        end else if (cnt >= limit - 1'b1) begin
            filt <= din;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    assign dout = bypass ? din : filt;

endmodule

// File: rtl/dbn_unit.sv
module dbn_unit
    import dbn_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);

    reg_req_t                          req;
    logic [NUM_PINS-1:0]               code_hi;
    logic [NUM_PINS-1:0]               code_lo;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] period;
    logic [NUM_PINS-1:0]               code_chg;
    logic [NUM_TIMERS-1:0]             period_wr;

    logic [NUM_PINS-1:0]               pin_bypass;
    logic [NUM_PINS-1:0]               pin_restart;
    logic [NUM_PINS-1:0][DATA_W-1:0]   pin_limit;
    logic [NUM_PINS-1:0][DATA_W-1:0]   pin_cnt;

    assign req = '{en: reg_en, we: reg_we, addr: reg_addr, wdata: reg_wdata};

    dbn_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .rdata     (reg_rdata),
        .code_hi   (code_hi),
        .code_lo   (code_lo),
        .period    (period),
        .code_chg  (code_chg),
        .period_wr (period_wr)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [CODE_W-1:0] code;
        logic              tmr_wr;

        assign code = {code_hi[i], code_lo[i]};

        always_comb begin
            pin_limit[i] = '0;
            tmr_wr       = 1'b0;
            for (int k = 0; k < NUM_TIMERS; k++) begin
                if (code == CODE_W'(k + 1)) begin
                    pin_limit[i] = period[k];
                    tmr_wr       = period_wr[k];
                end
            end
        end

        assign pin_bypass[i]  = (code == '0) || (pin_limit[i] == '0);
        assign pin_restart[i] = code_chg[i] || tmr_wr;

        dbn_filter u_filter (
            .clk     (clk),
            .rst     (rst),
            .din     (pin_in[i]),
            .bypass  (pin_bypass[i]),
            .limit   (pin_limit[i]),
            .restart (pin_restart[i]),
            .dout    (pin_out[i]),
            .cnt     (pin_cnt[i])
        );
    end

endmodule

// File: rtl/dbn_unit_chk.sv
module dbn_unit_chk
    import dbn_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_PINS-1:0]               pin_in,
    input logic [NUM_PINS-1:0]               pin_out,
    input logic                              reg_en,
    input logic                              reg_we,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [DATA_W-1:0]                 reg_wdata,
    input logic [DATA_W-1:0]                 reg_rdata,
    input logic [NUM_PINS-1:0]               pin_bypass,
    input logic [NUM_PINS-1:0][DATA_W-1:0]   pin_limit,
    input logic [NUM_PINS-1:0][DATA_W-1:0]   pin_cnt
);

    logic cfg_wr;
    logic per_addr;

    assign cfg_wr   = reg_en && reg_we;
    assign per_addr = reg_decode(reg_addr).kind == RK_PERIOD;

    // R1: leaving reset, every pin is in bypass
    p_reset_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pin_out == pin_in);

    // R2: a period word reads back what was written the cycle before
    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_we && per_addr && !$past(rst) && $past(cfg_wr)
         && reg_addr == $past(reg_addr)) |-> reg_rdata == $past(reg_wdata));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        // R3: a bypassed pin keeps its count at zero
        p_bypass_idle_r3: assert property (@(posedge clk) disable iff (rst)
            pin_bypass[i] |=> pin_cnt[i] == '0);

        // R4: the count of a debounced pin never reaches its period
        p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (rst)
            !pin_bypass[i] |-> pin_cnt[i] < pin_limit[i]);

        // R4: a debounced pin holds while its input agrees with its output
        p_hold_when_equal_r4: assert property (@(posedge clk) disable iff (rst)
            (!pin_bypass[i] && pin_in[i] == pin_out[i])
            |=> (pin_bypass[i] || pin_out[i] == $past(pin_out[i])));

        // R4: a period of one releases after a single differing edge
        p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
            (!pin_bypass[i] && pin_limit[i] == DATA_W'(1) && pin_in[i] != pin_out[i] && !cfg_wr)
            |=> (pin_bypass[i] || pin_out[i] == $past(pin_in[i])));
    end

endmodule

bind dbn_unit dbn_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pin_bypass (pin_bypass),
    .pin_limit  (pin_limit),
    .pin_cnt    (pin_cnt)
);

// File: tb/dbn_unit_bench.sv
module dbn_unit_bench;

    localparam logic [7:0] A_HI  = 8'h00;
    localparam logic [7:0] A_LO  = 8'h04;
    localparam logic [7:0] A_P1  = 8'h10;
    localparam logic [7:0] A_P2  = 8'h14;
    localparam logic [7:0] A_P3  = 8'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    logic [31:0] sh_hi = '0;
    logic [31:0] sh_lo = '0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    dbn_unit u_dbn_unit (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic set_code(input int pin, input logic [1:0] code);
        sh_hi[pin] = code[1];
        sh_lo[pin] = code[0];
        wr(A_HI, sh_hi);
        wr(A_LO, sh_lo);
    endtask

    // Input already changed at a negedge; expect release after edge p.
    task automatic expect_release(input int pin, input int p, input logic nv, input string tag);
        for (int k = 1; k <= p; k++) begin
            @(posedge clk); #1;
            check(pin_out[pin] == ((k == p) ? nv : ~nv), tag, 32'(pin_out[pin]), 32'((k == p) ? nv : ~nv));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements) act=timeout exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  addrs [5];
        addrs = '{A_HI, A_LO, A_P1, A_P2, A_P3};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        foreach (addrs[j]) begin
            rd(addrs[j], r);
            check(r == 32'h0, "R1 reset register", r, 32'h0);
        end
        @(negedge clk);
        pin_in = 32'hA5C3_0F96;
        #1 check(pin_out == pin_in, "R1 bypass after reset", pin_out, pin_in);

        // R3: code 0 follows input in the same cycle
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            pin_in = 32'h1357_9BDF * (j + 3);
            #1 check(pin_out == pin_in, "R3 bypass same cycle", pin_out, pin_in);
        end
        @(negedge clk);
        pin_in = '0;

        // R2: readback and unmapped addresses
        foreach (addrs[j]) begin
            wr(addrs[j], 32'hC0DE_0000 + 32'(j * 17));
            rd(addrs[j], r);
            check(r == 32'hC0DE_0000 + 32'(j * 17), "R2 readback", r, 32'hC0DE_0000 + 32'(j * 17));
        end
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        rd(8'h08, r);
        check(r == 32'h0, "R2 unmapped read", r, 32'h0);
        rd(8'h1C, r);
        check(r == 32'h0, "R2 unmapped read", r, 32'h0);
        foreach (addrs[j]) begin
            rd(addrs[j], r);
            check(r == 32'hC0DE_0000 + 32'(j * 17), "R2 unmapped write ignored", r, 32'hC0DE_0000 + 32'(j * 17));
        end
        sh_hi = '0; sh_lo = '0;
        foreach (addrs[j]) wr(addrs[j], 32'h0);

        // R4: sweep of codes and periods, both edges
        for (int t = 1; t <= 3; t++) begin
            for (int p = 1; p <= 6; p++) begin
                int pin;
                pin = (t * 7 + p) % 32;
                wr(A_P1 + 8'(4 * (t - 1)), 32'(p));
                set_code(pin, 2'(t));
                repeat (2) @(negedge clk);
                pin_in[pin] = 1'b1;
                expect_release(pin, p, 1'b1, "R4 rise delay");
                @(negedge clk);
                pin_in[pin] = 1'b0;
                expect_release(pin, p, 1'b0, "R4 fall delay");
                set_code(pin, 2'd0);
            end
        end

        // R5: bounce restarts the count
        wr(A_P1, 32'd4);
        set_code(3, 2'd1);
        @(negedge clk);
        pin_in[3] = 1'b1;
        repeat (2) begin
            @(posedge clk); #1;
            check(pin_out[3] == 1'b0, "R5 hold before bounce", 32'(pin_out[3]), 32'h0);
        end
        @(negedge clk);
        pin_in[3] = 1'b0;
        @(posedge clk); #1;
        check(pin_out[3] == 1'b0, "R5 bounce back", 32'(pin_out[3]), 32'h0);
        @(negedge clk);
        pin_in[3] = 1'b1;
        expect_release(3, 4, 1'b1, "R5 full period after bounce");
        @(negedge clk);
        pin_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        set_code(3, 2'd0);

        // R6: zero period behaves as bypass
        wr(A_P2, 32'd0);
        set_code(7, 2'd2);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            pin_in[7] = j[0] ? 1'b0 : 1'b1;
            #1 check(pin_out[7] == pin_in[7], "R6 zero period passes", 32'(pin_out[7]), 32'(pin_in[7]));
        end
        @(negedge clk);
        pin_in[7] = 1'b0;
        set_code(7, 2'd0);

        // R7: rewrite of the selected period restarts the count
        wr(A_P3, 32'd5);
        set_code(9, 2'd3);
        @(negedge clk);
        pin_in[9] = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            check(pin_out[9] == 1'b0, "R7 hold before rewrite", 32'(pin_out[9]), 32'h0);
        end
        wr(A_P3, 32'd5);
        expect_release(9, 5, 1'b1, "R7 period rewrite restart");
        @(negedge clk);
        pin_in[9] = 1'b0;
        repeat (7) @(negedge clk);

        // R7: code change restarts the count
        wr(A_P1, 32'd5);
        @(negedge clk);
        pin_in[9] = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            check(pin_out[9] == 1'b0, "R7 hold before code change", 32'(pin_out[9]), 32'h0);
        end
        sh_hi[9] = 1'b0;
        wr(A_HI, sh_hi);
        expect_release(9, 5, 1'b1, "R7 code change restart");
        @(negedge clk);
        pin_in[9] = 1'b0;
        repeat (7) @(negedge clk);
        set_code(9, 2'd0);

        // R8: shared and independent periods
        wr(A_P1, 32'd2);
        wr(A_P2, 32'd4);
        set_code(0, 2'd1);
        set_code(1, 2'd1);
        set_code(2, 2'd2);
        @(negedge clk);
        pin_in[2:0] = 3'b111;
        pin_in[20]  = 1'b1;
        #1 check(pin_out[20] == 1'b1, "R3 bypass pin beside debounced pins", 32'(pin_out[20]), 32'h1);
        for (int k = 1; k <= 4; k++) begin
            logic [2:0] e;
            @(posedge clk); #1;
            e = {(k >= 4), (k >= 2), (k >= 2)};
            check(pin_out[2:0] == e, "R8 shared period", 32'(pin_out[2:0]), 32'(e));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule